// File: doc/BRIEF.md
# Bus Debug Trigger Unit

This block sits beside a shared system bus and watches every transfer. On each cycle where the transfer-valid strobe is high, it compares the bus address against two programmable reference values. It checks whether the master granted the bus is picked by a mask. It also tests the transfer opcode and the supervisor, write and read flags against a chosen condition. The three condition terms (address, grant and status) can each be switched on or off. A small combiner then joins them with AND or OR, as three configuration bits select.

When the combined condition holds while the unit is armed, the unit emits a single-cycle trigger pulse and sets a sticky triggered flag. It then disarms itself. Software must write the rearm bit before the next matching transfer can fire the unit again. Configuration goes through a plain word-wide register port with a combinational read path. The port holds two address references, a control word, a master mask and a flag-select word.

Top module: `dbg_bus_trig`

## Requirements
- R1: After reset, trig_pulse and trig_sticky are 0 and the unit is disarmed. Every register reads 0, except the master mask, which reads all ones in its NMST low bits (0x0000FFFF by default).
- R2: Register offsets on cfg_addr are 0 for address reference A, 1 for address reference B, 2 for control, 3 for master mask and 4 for flag select. A write on a rising edge is read back the same cycle through cfg_rdata. Bits beyond a register's width read 0. Control bit 13 (rearm) always reads 0.
- R3: Comparator A takes its mode from control bits [1:0] and comparator B from bits [3:2]. The codes are: 00 off, 01 address equal to the reference, 10 address greater than or equal to it, 11 address less than it. A comparator that is off ignores its reference.
- R4: Control bit 9 enables the grant term. The term is true when the mask bit indexed by bus_mid is 0.
- R5: Control bit 8 enables the status term. The opcode field is control bits [7:4]. A value of 0 accepts every opcode except the no-operation code 4'hF. Any other value requires an exact opcode match, and 4'hF never matches. Flag-select bit 0 requires bus_sv=1, bit 1 requires bus_wr=1 and bit 2 requires bus_rd=1. A flag that is not selected has no effect.
- R6: The combine field is control bits [12:10]. Bit 11 selects AND (1) or OR (0) of the two address hits. Bit 10 joins the grant term to the address result with AND (1) or OR (0). Bit 12 then joins the status term the same way. A disabled term is false in an OR and true in an AND. No match occurs when every term is disabled.
- R7: Bus inputs are evaluated only when bus_valid is 1.
- R8: A match sampled on a rising edge while armed drives trig_pulse high for exactly the following cycle, sets trig_sticky and disarms the unit. Later matches give no pulse.
- R9: Writing control with bit 13 set arms the unit and clears trig_sticky from the next cycle on. A transfer sampled on the same edge as the rearm write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Transfer valid strobe |
| bus_addr | input | 32 | Transfer address |
| bus_opc | input | 4 | Transfer opcode |
| bus_mid | input | 4 | ID of the granted master |
| bus_sv | input | 1 | Supervisor flag |
| bus_wr | input | 1 | Write flag |
| bus_rd | input | 1 | Read flag |
| trig_pulse | output | 1 | One-cycle trigger event |
| trig_sticky | output | 1 | Triggered flag, held until rearm |

## Verification
A register write lands on the rising edge where cfg_wr is high. Its readback is combinational, so the bench sets cfg_addr on a falling edge and samples cfg_rdata a fraction of a cycle later. A transfer is sampled on one rising edge and its trig_pulse and trig_sticky appear after that edge, so the bench checks them on the next falling edge. It checks the following falling edge for the pulse returning to 0. A rearm takes effect on its own edge, which the bench covers by driving a rearm write and a matching transfer in the same cycle and expecting no pulse.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  localparam int REG_AW    = 3;
  localparam int OPC_W     = 4;
  localparam int CTRL_FW   = 13;
  localparam int REARM_BIT = 13;
  localparam int SSEL_W    = 3;

  localparam logic [OPC_W-1:0] OPC_NOP = 4'hF;

  localparam logic [REG_AW-1:0] OFS_ADRA = 3'd0;
  localparam logic [REG_AW-1:0] OFS_ADRB = 3'd1;
  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd2;
  localparam logic [REG_AW-1:0] OFS_GMSK = 3'd3;
  localparam logic [REG_AW-1:0] OFS_SSEL = 3'd4;

  typedef enum logic [1:0] {
    AM_OFF = 2'b00,
    AM_EQ  = 2'b01,
    AM_GE  = 2'b10,
    AM_LT  = 2'b11
  } amode_e;

  // packed from MSB down so that the field layout matches the control word
  typedef struct packed {
    logic [2:0]       comb;
    logic             gnt_en;
    logic             opc_en;
    logic [OPC_W-1:0] opc_sel;
    amode_e           b_mode;
    amode_e           a_mode;
  } ctrl_t;

  typedef struct packed {
    logic need_rd;
    logic need_wr;
    logic need_sv;
  } ssel_t;

endpackage

// File: rtl/dbt_regs.sv
module dbt_regs
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NMST   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [REG_AW-1:0]      cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  output logic [1:0][ADDR_W-1:0] adr_ref,
  output ctrl_t                  ctrl,
  output logic [NMST-1:0]        gmask,
  output ssel_t                  ssel,
  output logic                   rearm_wr
);

  logic [1:0] en_adr;
  logic       en_ctrl;
  logic       en_gmsk;
  logic       en_ssel;

  logic [1:0][ADDR_W-1:0] adr_q, adr_n;
  ctrl_t                  ctrl_q, ctrl_n;
  logic [NMST-1:0]        gmask_q, gmask_n;
  ssel_t                  ssel_q, ssel_n;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  // clock enables
  assign en_ctrl  = cfg_wr && (cfg_addr == OFS_CTRL);
  assign en_gmsk  = cfg_wr && (cfg_addr == OFS_GMSK);
  assign en_ssel  = cfg_wr && (cfg_addr == OFS_SSEL);
  assign rearm_wr = en_ctrl && cfg_wdata[REARM_BIT];

  // address reference registers, one per comparator
  for (genvar g = 0; g < 2; g++) begin : g_adr
    assign en_adr[g] = cfg_wr && (cfg_addr == REG_AW'(32'(OFS_ADRA) + g));

    always_comb begin
      adr_n[g] = adr_q[g];
      if (en_adr[g]) adr_n[g] = cfg_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adr_q[g] <= '0;
      else        adr_q[g] <= adr_n[g];
    end
  end

  // next-state for the remaining registers
  always_comb begin
    ctrl_n  = ctrl_q;
    gmask_n = gmask_q;
    ssel_n  = ssel_q;
    if (en_ctrl) ctrl_n  = ctrl_t'(cfg_wdata[CTRL_FW-1:0]);
    if (en_gmsk) gmask_n = cfg_wdata[NMST-1:0];
    if (en_ssel) ssel_n  = ssel_t'(cfg_wdata[SSEL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      gmask_q <= '1;
      ssel_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      gmask_q <= gmask_n;
      ssel_q  <= ssel_n;
    end
  end

  // combinational readback
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_ADRA: cfg_rdata[ADDR_W-1:0]  = adr_q[0];
      OFS_ADRB: cfg_rdata[ADDR_W-1:0]  = adr_q[1];
      OFS_CTRL: cfg_rdata[CTRL_FW-1:0] = ctrl_q;
      OFS_GMSK: cfg_rdata[NMST-1:0]    = gmask_q;
      OFS_SSEL: cfg_rdata[SSEL_W-1:0]  = ssel_q;
      default:  cfg_rdata = '0;
    endcase
  end

  assign adr_ref = adr_q;
  assign ctrl    = ctrl_q;
  assign gmask   = gmask_q;
  assign ssel    = ssel_q;

  // R2: the master mask changes only through its own offset
  p_gmask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_gmsk |=> $stable(gmask_q));

  // R2: the control word changes only through its own offset
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/dbt_addr_cmp.sv
module dbt_addr_cmp
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  amode_e            mode,
  input  logic [ADDR_W-1:0] ref_val,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              en,
  output logic              hit
);

  always_comb begin
    en = (mode != AM_OFF);
    case (mode)
      AM_EQ:   hit = (bus_addr == ref_val);
      AM_GE:   hit = (bus_addr >= ref_val);
      AM_LT:   hit = (bus_addr <  ref_val);
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbt_combine.sv
module dbt_combine
  import dbt_pkg::*;
#(
  parameter int NMST  = 16,
  parameter int MID_W = 4
) (
  input  ctrl_t            ctrl,
  input  logic [NMST-1:0]  gmask,
  input  ssel_t            ssel,
  input  logic [1:0]       a_en,
  input  logic [1:0]       a_hit,
  input  logic [OPC_W-1:0] bus_opc,
  input  logic [MID_W-1:0] bus_mid,
  input  logic             bus_sv,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic             match
);

  logic adr_en, adr_and, adr_or, adr_val;
  logic gnt_val;
  logic opc_ok, flg_ok, sts_val;
  logic t1_en, t1_val, t2_en, t2_val;

  always_comb begin
    // address term: two hits joined by OR or AND
    adr_en  = |a_en;
    adr_and = (!a_en[0] || a_hit[0]) && (!a_en[1] || a_hit[1]);
    adr_or  = |(a_en & a_hit);
    adr_val = ctrl.comb[1] ? adr_and : adr_or;

    // grant term: cleared mask bit selects the master
    gnt_val = (32'(bus_mid) < NMST) ? !gmask[bus_mid] : 1'b0;

    // status term: opcode condition plus selected flags
    opc_ok  = (bus_opc != OPC_NOP) &&
              ((ctrl.opc_sel == '0) || (bus_opc == ctrl.opc_sel));
    flg_ok  = (!ssel.need_sv || bus_sv) &&
              (!ssel.need_wr || bus_wr) &&
              (!ssel.need_rd || bus_rd);
    sts_val = opc_ok && flg_ok;

    // fold grant onto the address result; disabled terms are the identity
    t1_en  = adr_en || ctrl.gnt_en;
    t1_val = ctrl.comb[0]
           ? ((!adr_en || adr_val) && (!ctrl.gnt_en || gnt_val))
           : ((adr_en && adr_val) || (ctrl.gnt_en && gnt_val));

    // fold status onto that result
    t2_en  = t1_en || ctrl.opc_en;
    t2_val = ctrl.comb[2]
           ? ((!t1_en || t1_val) && (!ctrl.opc_en || sts_val))
           : ((t1_en && t1_val) || (ctrl.opc_en && sts_val));

    match = t2_en && t2_val;
  end

endmodule

// File: rtl/dbt_fire.sv
module dbt_fire (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_valid,
  input  logic match,
  input  logic rearm_wr,
  output logic trig_pulse,
  output logic trig_sticky
);

  logic hit;
  logic armed_q, armed_n;
  logic pulse_q, pulse_n;
  logic sticky_q, sticky_n;

  assign hit = bus_valid && match;

  always_comb begin
    armed_n  = armed_q;
    pulse_n  = 1'b0;
    sticky_n = sticky_q;
    if (rearm_wr) begin
      armed_n  = 1'b1;
      sticky_n = 1'b0;
    end else if (armed_q && hit) begin
      armed_n  = 1'b0;
      pulse_n  = 1'b1;
      sticky_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      pulse_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      armed_q  <= armed_n;
      pulse_q  <= pulse_n;
      sticky_q <= sticky_n;
    end
  end

  assign trig_pulse  = pulse_q;
  assign trig_sticky = sticky_q;

  // R8: pulse lasts exactly one cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R8: a pulse comes with the sticky flag and a disarmed unit
  p_pulse_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (trig_sticky && !armed_q));

  // R7: no pulse follows a cycle without a valid transfer
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !trig_pulse);

  // R9: sticky holds until a rearm write
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sticky && !rearm_wr) |=> trig_sticky);

  // R9: rearm arms, clears sticky and suppresses a same-edge pulse
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_wr |=> (armed_q && !trig_sticky && !trig_pulse));

endmodule

// File: rtl/dbg_bus_trig.sv
module dbg_bus_trig
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NMST   = 16,
  localparam int MID_W = (NMST > 1) ? $clog2(NMST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OPC_W-1:0]  bus_opc,
  input  logic [MID_W-1:0]  bus_mid,
  input  logic              bus_sv,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              trig_pulse,
  output logic              trig_sticky
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [1:0][ADDR_W-1:0] adr_ref;
  ctrl_t                  ctrl;
  logic [NMST-1:0]        gmask;
  ssel_t                  ssel;
  logic                   rearm_wr;
  logic [1:0]             a_en, a_hit;
  amode_e                 a_mode [2];
  logic                   match;

  dbt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NMST(NMST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .adr_ref   (adr_ref),
    .ctrl      (ctrl),
    .gmask     (gmask),
    .ssel      (ssel),
    .rearm_wr  (rearm_wr)
  );

  assign a_mode[0] = ctrl.a_mode;
  assign a_mode[1] = ctrl.b_mode;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    dbt_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .mode     (a_mode[g]),
      .ref_val  (adr_ref[g]),
      .bus_addr (bus_addr),
      .en       (a_en[g]),
      .hit      (a_hit[g])
    );
  end

  dbt_combine #(.NMST(NMST), .MID_W(MID_W)) u_comb (
    .ctrl    (ctrl),
    .gmask   (gmask),
    .ssel    (ssel),
    .a_en    (a_en),
    .a_hit   (a_hit),
    .bus_opc (bus_opc),
    .bus_mid (bus_mid),
    .bus_sv  (bus_sv),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .match   (match)
  );

  dbt_fire u_fire (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bus_valid   (bus_valid),
    .match       (match),
    .rearm_wr    (rearm_wr),
    .trig_pulse  (trig_pulse),
    .trig_sticky (trig_sticky)
  );

  // R3: a disabled comparator never reports a hit
  p_cmp_off_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl.a_mode == AM_OFF) |-> !a_hit[0]);

endmodule

// File: tb/dbg_bus_trig_test.sv
module dbg_bus_trig_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [3:0]  bus_opc;
  logic [3:0]  bus_mid;
  logic        bus_sv, bus_wr, bus_rd;
  logic        trig_pulse, trig_sticky;

  int checks = 0;
  int errors = 0;
  logic [31:0] cur_ctrl = '0;

  always #2.5 clk = ~clk;

  dbg_bus_trig uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_opc(bus_opc), .bus_mid(bus_mid),
    .bus_sv(bus_sv), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .trig_pulse(trig_pulse), .trig_sticky(trig_sticky)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int am, int bm, int opc, bit oe, bit ge, int comb);
    logic [31:0] v = '0;
    v[1:0]   = am[1:0];
    v[3:2]   = bm[1:0];
    v[7:4]   = opc[3:0];
    v[8]     = oe;
    v[9]     = ge;
    v[12:10] = comb[2:0];
    return v;
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic set_ctrl(logic [31:0] c);
    cur_ctrl = c;
    wr(3'd2, c);
  endtask

  task automatic rearm();
    wr(3'd2, cur_ctrl | 32'h2000);
  endtask

  // drives one transfer; returns at the falling edge after its sampling edge
  task automatic xfer(logic [31:0] a, logic [3:0] o, logic [3:0] m, bit sv, bit w, bit r);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_opc = o; bus_mid = m;
    bus_sv = sv; bus_wr = w; bus_rd = r;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic fire_case(string tag, logic [31:0] a, logic [3:0] o, logic [3:0] m,
                           bit sv, bit w, bit r, bit exp);
    rearm();
    xfer(a, o, m, sv, w, r);
    chk(tag, {31'b0, trig_pulse}, {31'b0, exp});
  endtask

  task automatic t_reset();
    chk("R1 pulse at reset", {31'b0, trig_pulse}, 32'd0);
    chk("R1 sticky at reset", {31'b0, trig_sticky}, 32'd0);
    rd_chk("R1 ref A reset", 3'd0, 32'h0);
    rd_chk("R1 ref B reset", 3'd1, 32'h0);
    rd_chk("R1 control reset", 3'd2, 32'h0);
    rd_chk("R1 mask reset", 3'd3, 32'h0000_FFFF);
    rd_chk("R1 flag select reset", 3'd4, 32'h0);
    // configure a catch-all condition without rearming: disarmed, no pulse
    set_ctrl(mk(2, 0, 0, 0, 0, 0));
    xfer(32'h10, 4'h2, 4'h0, 0, 0, 0);
    chk("R1 disarmed after reset", {31'b0, trig_pulse}, 32'd0);
  endtask

  task automatic t_regs();
    wr(3'd0, 32'hA5A5_0001);
    rd_chk("R2 ref A readback", 3'd0, 32'hA5A5_0001);
    wr(3'd1, 32'h5A5A_0002);
    rd_chk("R2 ref B readback", 3'd1, 32'h5A5A_0002);
    wr(3'd3, 32'h1234_FFF7);
    rd_chk("R2 mask width", 3'd3, 32'h0000_FFF7);
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R2 flag select width", 3'd4, 32'h0000_0007);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk("R2 control rearm reads 0", 3'd2, 32'h0000_1FFF);
    wr(3'd4, 32'h0);
    set_ctrl(32'h0);
  endtask

  task automatic t_addr();
    wr(3'd0, 32'h01FF_FFFF);
    set_ctrl(mk(2, 0, 0, 0, 0, 0));
    fire_case("R3 GE below", 32'h01FF_FFFE, 4'h2, 0, 0, 0, 0, 0);
    fire_case("R3 GE equal", 32'h01FF_FFFF, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R3 GE top", 32'hFFFF_FFFF, 4'h2, 0, 0, 0, 0, 1);
    wr(3'd0, 32'h1000);
    set_ctrl(mk(1, 0, 0, 0, 0, 0));
    fire_case("R3 EQ match", 32'h1000, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R3 EQ miss", 32'h1004, 4'h2, 0, 0, 0, 0, 0);
    set_ctrl(mk(3, 0, 0, 0, 0, 0));
    fire_case("R3 LT below", 32'h0FFF, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R3 LT equal", 32'h1000, 4'h2, 0, 0, 0, 0, 0);
    wr(3'd1, 32'h2000);
    set_ctrl(mk(0, 1, 0, 0, 0, 0));
    fire_case("R3 comparator B match", 32'h2000, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R3 comparator B miss", 32'h2001, 4'h2, 0, 0, 0, 0, 0);
    set_ctrl(mk(0, 0, 0, 0, 0, 0));
    fire_case("R6 all terms off", 32'h2000, 4'h2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_grant();
    wr(3'd3, 32'hFFF7);
    set_ctrl(mk(0, 0, 0, 0, 1, 0));
    fire_case("R4 selected master", 32'h0, 4'h2, 4'd3, 0, 0, 0, 1);
    fire_case("R4 other master", 32'h0, 4'h2, 4'd2, 0, 0, 0, 0);
    wr(3'd3, 32'hFFFF);
    fire_case("R4 empty mask", 32'h0, 4'h2, 4'd3, 0, 0, 0, 0);
  endtask

  task automatic t_status();
    set_ctrl(mk(0, 0, 0, 1, 0, 0));
    fire_case("R5 NOP rejected", 32'h0, 4'hF, 0, 0, 0, 0, 0);
    fire_case("R5 any opcode 0", 32'h0, 4'h0, 0, 0, 0, 0, 1);
    fire_case("R5 any opcode 7", 32'h0, 4'h7, 0, 0, 0, 0, 1);
    set_ctrl(mk(0, 0, 5, 1, 0, 0));
    fire_case("R5 exact match", 32'h0, 4'h5, 0, 0, 0, 0, 1);
    fire_case("R5 exact miss", 32'h0, 4'h6, 0, 0, 0, 0, 0);
    set_ctrl(mk(0, 0, 15, 1, 0, 0));
    fire_case("R5 NOP never exact", 32'h0, 4'hF, 0, 0, 0, 0, 0);
    set_ctrl(mk(0, 0, 0, 1, 0, 0));
    wr(3'd4, 32'h1);
    fire_case("R5 supervisor required, absent", 32'h0, 4'h2, 0, 0, 1, 1, 0);
    fire_case("R5 supervisor required, present", 32'h0, 4'h2, 0, 1, 0, 0, 1);
    wr(3'd4, 32'h6);
    fire_case("R5 write and read, read absent", 32'h0, 4'h2, 0, 1, 1, 0, 0);
    fire_case("R5 write and read present", 32'h0, 4'h2, 0, 0, 1, 1, 1);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_combine();
    wr(3'd0, 32'h100);
    wr(3'd1, 32'h200);
    set_ctrl(mk(1, 1, 0, 0, 0, 0));
    fire_case("R6 OR hit A", 32'h100, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R6 OR hit B", 32'h200, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R6 OR none", 32'h300, 4'h2, 0, 0, 0, 0, 0);
    set_ctrl(mk(2, 3, 0, 0, 0, 2));
    fire_case("R6 AND inside", 32'h150, 4'h2, 0, 0, 0, 0, 1);
    fire_case("R6 AND above", 32'h250, 4'h2, 0, 0, 0, 0, 0);
    fire_case("R6 AND below", 32'h050, 4'h2, 0, 0, 0, 0, 0);
    wr(3'd3, 32'hFFFB);
    set_ctrl(mk(1, 0, 0, 0, 1, 0));
    fire_case("R6 grant OR via grant", 32'h300, 4'h2, 4'd2, 0, 0, 0, 1);
    fire_case("R6 grant OR via address", 32'h100, 4'h2, 4'd5, 0, 0, 0, 1);
    fire_case("R6 grant OR neither", 32'h300, 4'h2, 4'd5, 0, 0, 0, 0);
    set_ctrl(mk(1, 0, 0, 1, 0, 4));
    fire_case("R6 status AND, NOP", 32'h100, 4'hF, 0, 0, 0, 0, 0);
    fire_case("R6 status AND, both", 32'h100, 4'h1, 0, 0, 0, 0, 1);
    fire_case("R6 status AND, addr miss", 32'h104, 4'h1, 0, 0, 0, 0, 0);
    set_ctrl(mk(0, 0, 0, 0, 1, 3));
    fire_case("R6 disabled address in AND", 32'h900, 4'h2, 4'd2, 0, 0, 0, 1);
    fire_case("R6 disabled address, grant miss", 32'h900, 4'h2, 4'd5, 0, 0, 0, 0);
    // window above a threshold, one master, any real opcode
    wr(3'd0, 32'h01FF_FFFF);
    wr(3'd3, 32'hFFF7);
    set_ctrl(mk(2, 0, 0, 1, 1, 5));
    fire_case("R6 full AND hit", 32'h8000_0000, 4'h2, 4'd3, 0, 0, 0, 1);
    fire_case("R6 full AND wrong master", 32'h8000_0000, 4'h2, 4'd4, 0, 0, 0, 0);
    fire_case("R6 full AND low address", 32'h0100_0000, 4'h2, 4'd3, 0, 0, 0, 0);
    fire_case("R6 full AND NOP", 32'h8000_0000, 4'hF, 4'd3, 0, 0, 0, 0);
  endtask

  task automatic t_once();
    wr(3'd0, 32'h0);
    set_ctrl(mk(2, 0, 0, 0, 0, 0));
    rearm();
    chk("R9 sticky clear after rearm", {31'b0, trig_sticky}, 32'd0);
    xfer(32'h40, 4'h2, 0, 0, 0, 0);
    chk("R8 pulse on match", {31'b0, trig_pulse}, 32'd1);
    chk("R8 sticky set", {31'b0, trig_sticky}, 32'd1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, trig_pulse}, 32'd0);
    xfer(32'h40, 4'h2, 0, 0, 0, 0);
    chk("R8 second match ignored", {31'b0, trig_pulse}, 32'd0);
    chk("R8 sticky held", {31'b0, trig_sticky}, 32'd1);
  endtask

  task automatic t_rearm();
    rearm();
    chk("R9 rearm clears sticky", {31'b0, trig_sticky}, 32'd0);
    xfer(32'h40, 4'h2, 0, 0, 0, 0);
    chk("R9 fires after rearm", {31'b0, trig_pulse}, 32'd1);
    // rearm write and matching transfer on the same edge
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'd2; cfg_wdata = cur_ctrl | 32'h2000;
    bus_valid = 1'b1; bus_addr = 32'h40; bus_opc = 4'h2;
    @(negedge clk);
    cfg_wr = 1'b0; bus_valid = 1'b0;
    chk("R9 same-edge transfer no pulse", {31'b0, trig_pulse}, 32'd0);
    chk("R9 same-edge sticky clear", {31'b0, trig_sticky}, 32'd0);
    xfer(32'h40, 4'h2, 0, 0, 0, 0);
    chk("R9 next transfer fires", {31'b0, trig_pulse}, 32'd1);
  endtask

  task automatic t_valid();
    rearm();
    @(negedge clk);
    bus_valid = 1'b0; bus_addr = 32'h40; bus_opc = 4'h2;
    @(negedge clk);
    chk("R7 no pulse without valid", {31'b0, trig_pulse}, 32'd0);
    chk("R7 sticky untouched without valid", {31'b0, trig_sticky}, 32'd0);
    xfer(32'h40, 4'h2, 0, 0, 0, 0);
    chk("R7 still armed, fires on valid", {31'b0, trig_pulse}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_opc = '0; bus_mid = '0;
    bus_sv = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_addr();
    t_grant();
    t_status();
    t_combine();
    t_once();
    t_rearm();
    t_valid();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule